// File: doc/BRIEF.md
# Floating-Point Sign and Word-Merge Unit

This block carries out the non-arithmetic moves of a 64-bit floating-point register file: a plain move, three sign manipulations (clear, set, invert), a copy-sign that joins the sign of one operand to the magnitude of the other, and two merges that build a result from 32-bit words of both operands. None of these operations interprets the operand. A NaN, an infinity or a denormal passes through bit for bit, and the status register is only read, never written.

An issue stage presents two operands, an operation code, a record flag, a unit-enable flag and the current 32-bit status word for one cycle with `in_valid` high. One cycle later the unit presents the result with a write strobe for the register file. If the record flag was set, it also presents the top status nibble with a condition-field strobe. If the unit was disabled, it raises an unavailable-unit exception strobe instead of writing. Every output is registered. The result holds its last written value between writes.

Top module: `fpmove_unit`

## Requirements
- R1: After reset, `res_data` is zero and `res_we`, `cond_val`, `cond_we` and `unavail_exc` are all zero.
- R2: Operation codes are 0 move, 1 absolute, 2 negative absolute, 3 negate, 4 copy-sign, 5 even-word merge, 6 odd-word merge and 7 reserved. Move returns B unchanged. Absolute returns B with bit 63 cleared. Negative absolute returns B with bit 63 set. Negate returns B with bit 63 inverted. In each case bits 62:0 equal B's.
- R3: Copy-sign returns bit 63 of A with bits 62:0 of B.
- R4: Even-word merge returns A[63:32] in result bits 63:32 and B[63:32] in result bits 31:0.
- R5: Odd-word merge returns A[31:0] in result bits 63:32 and B[31:0] in result bits 31:0.
- R6: NaN and infinity operands are not detected or altered. Only the bits named in R2–R5 change, and no output other than those given in R7–R10 reacts to the operand class.
- R7: A valid, enabled, legal operation raises `res_we` for exactly the cycle after `in_valid`, with the result on `res_data` in that cycle. Without such an operation `res_we` is low and `res_data` keeps its previous value.
- R8: For codes 0–4 with the record flag set, `cond_we` pulses in the cycle after `in_valid` and `cond_val` equals status bits 31:28 as sampled with `in_valid`. With the record flag clear, `cond_we` stays low and `cond_val` holds.
- R9: The merge codes 5 and 6 never raise `cond_we`, whatever the record flag.
- R10: With `unit_en` low, a valid input raises `unavail_exc` for the next cycle, with no write and no condition update, and `res_data` keeps its value.
- R11: `unavail_exc` and `res_we` are never high in the same cycle.
- R12: Code 7 with the unit enabled causes no write, no condition update and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 3 | Operation code (see R2) |
| rec_bit | input | 1 | Request a condition-field update |
| unit_en | input | 1 | Floating-point unit enabled |
| stat_word | input | 32 | Current status register |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| res_data | output | 64 | Registered result |
| res_we | output | 1 | Result write strobe |
| cond_val | output | 4 | Condition field value |
| cond_we | output | 1 | Condition field update strobe |
| unavail_exc | output | 1 | Unavailable-unit exception strobe |

## Verification
The bench sweeps every operation code against every combination of unit enable and record flag. Operands are drawn from a set that includes signed zeros, infinities and both kinds of NaN with distinct payloads. A design that swapped halves in a merge, or took the sign from the wrong operand in copy-sign, would show a result mismatch at once. So would one that quieted or canonicalised a NaN. A design that let a merge or a disabled unit touch the condition field, or wrote the register while raising the exception, would fail the strobe checks. After every operation an idle cycle confirms that the result and the condition field hold and that no strobe lingers.

// File: rtl/fpmove_pkg.sv
package fpmove_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_COPY     = 3'd0,
    OPC_ABS      = 3'd1,
    OPC_NABS     = 3'd2,
    OPC_NEG      = 3'd3,
    OPC_CSGN     = 3'd4,
    OPC_MRG_EVEN = 3'd5,
    OPC_MRG_ODD  = 3'd6,
    OPC_RSVD     = 3'd7
  } fpm_op_e;

  typedef struct packed {
    logic legal;
    logic is_merge;
    logic may_record;
  } fpm_dec_t;

  function automatic fpm_dec_t fpm_decode(input fpm_op_e op);
    fpm_dec_t d;
    d.legal      = (op != OPC_RSVD);
    d.is_merge   = (op == OPC_MRG_EVEN) || (op == OPC_MRG_ODD);
    d.may_record = d.legal && !d.is_merge;
    return d;
  endfunction

  // New sign bit for the sign-class operations
  function automatic logic fpm_new_sign(input fpm_op_e op, input logic sign_a,
                                        input logic sign_b);
    logic s;
    case (op)
      OPC_ABS:  s = 1'b0;
      OPC_NABS: s = 1'b1;
      OPC_NEG:  s = ~sign_b;
      OPC_CSGN: s = sign_a;
      default:  s = sign_b;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fpmove_sign_path.sv
module fpmove_sign_path
  import fpmove_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  fpm_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SIGN_POS = DATA_W - 1;

  logic new_sign;

  always_comb begin
    new_sign = fpm_new_sign(op, a[SIGN_POS], b[SIGN_POS]);
    y        = {new_sign, b[SIGN_POS-1:0]};
  end
endmodule

// File: rtl/fpmove_merge_path.sv
module fpmove_merge_path #(
  parameter int DATA_W = 64
) (
  input  logic              pick_even,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF  = DATA_W / 2;
  localparam int LANES = 2;

  logic [DATA_W-1:0] src [LANES];
  assign src[0] = b;
  assign src[1] = a;

  // Lane 1 (upper result half) draws from A, lane 0 from B
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign y[ln*HALF +: HALF] = pick_even ? src[ln][DATA_W-1 -: HALF]
                                          : src[ln][HALF-1:0];
  end
endmodule

// File: rtl/fpmove_ctrl.sv
module fpmove_ctrl
  import fpmove_pkg::*;
(
  input  logic    in_valid,
  input  logic    unit_en,
  input  logic    rec_bit,
  input  fpm_op_e op,
  output logic    do_write,
  output logic    do_cond,
  output logic    do_exc,
  output logic    use_merge
);
  fpm_dec_t dec;

  always_comb begin
    dec       = fpm_decode(op);
    do_exc    = in_valid && !unit_en;
    do_write  = in_valid && unit_en && dec.legal;
    do_cond   = in_valid && unit_en && rec_bit && dec.may_record;
    use_merge = dec.is_merge;
  end
endmodule

// File: rtl/fpmove_unit.sv
module fpmove_unit
  import fpmove_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int STAT_W = 32,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic              rec_bit,
  input  logic              unit_en,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_data,
  output logic              res_we,
  output logic [COND_W-1:0] cond_val,
  output logic              cond_we,
  output logic              unavail_exc
);
  fpm_op_e           op;
  logic [DATA_W-1:0] sign_res;
  logic [DATA_W-1:0] merge_res;
  logic [DATA_W-1:0] next_res;
  logic              do_write;
  logic              do_cond;
  logic              do_exc;
  logic              use_merge;
  logic [COND_W-1:0] stat_top;

  assign op       = fpm_op_e'(op_sel);
  assign stat_top = stat_word[STAT_W-1 -: COND_W];

  fpmove_ctrl u_ctrl (
    .in_valid (in_valid),
    .unit_en  (unit_en),
    .rec_bit  (rec_bit),
    .op       (op),
    .do_write (do_write),
    .do_cond  (do_cond),
    .do_exc   (do_exc),
    .use_merge(use_merge)
  );

  fpmove_sign_path #(.DATA_W(DATA_W)) u_sign (
    .op(op),
    .a (opnd_a),
    .b (opnd_b),
    .y (sign_res)
  );

  fpmove_merge_path #(.DATA_W(DATA_W)) u_merge (
    .pick_even(op == OPC_MRG_EVEN),
    .a        (opnd_a),
    .b        (opnd_b),
    .y        (merge_res)
  );

  assign next_res = use_merge ? merge_res : sign_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data    <= '0;
      res_we      <= 1'b0;
      cond_val    <= '0;
      cond_we     <= 1'b0;
      unavail_exc <= 1'b0;
    end else begin
      res_we      <= do_write;
      cond_we     <= do_cond;
      unavail_exc <= do_exc;
      if (do_write) res_data <= next_res;
      if (do_cond)  cond_val <= stat_top;
    end
  end
endmodule

// File: rtl/fpmove_checker.sv
module fpmove_checker #(
  parameter int DATA_W = 64,
  parameter int STAT_W = 32,
  parameter int COND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic              rec_bit,
  input logic              unit_en,
  input logic [STAT_W-1:0] stat_word,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] res_data,
  input logic              res_we,
  input logic [COND_W-1:0] cond_val,
  input logic              cond_we,
  input logic              unavail_exc
);
  localparam int HALF = DATA_W / 2;

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_we && unavail_exc));

  p_off_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !unit_en) |=> (unavail_exc && !res_we && !cond_we));

  p_merge_no_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 3'd5 || op_sel == 3'd6)) |=> !cond_we);

  p_cond_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && rec_bit && op_sel <= 3'd4) |=>
      (cond_we && cond_val == $past(stat_word[STAT_W-1 -: COND_W])));

  p_abs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && op_sel == 3'd1) |=>
      (res_we && !res_data[DATA_W-1] &&
       res_data[DATA_W-2:0] == $past(opnd_b[DATA_W-2:0])));

  p_csgn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && op_sel == 3'd4) |=>
      (res_data == {$past(opnd_a[DATA_W-1]), $past(opnd_b[DATA_W-2:0])}));

  p_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && op_sel == 3'd5) |=>
      (res_data == {$past(opnd_a[DATA_W-1 -: HALF]), $past(opnd_b[DATA_W-1 -: HALF])}));

  p_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && op_sel == 3'd6) |=>
      (res_data == {$past(opnd_a[HALF-1:0]), $past(opnd_b[HALF-1:0])}));

  p_rsvd_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_en && op_sel == 3'd7) |=> (!res_we && !cond_we && !unavail_exc));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_we && $stable(res_data)));
endmodule

bind fpmove_unit fpmove_checker #(
  .DATA_W(DATA_W), .STAT_W(STAT_W), .COND_W(COND_W)
) u_fpmove_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .rec_bit(rec_bit), .unit_en(unit_en), .stat_word(stat_word),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data), .res_we(res_we),
  .cond_val(cond_val), .cond_we(cond_we), .unavail_exc(unavail_exc)
);

// File: tb/test_fpmove_unit.sv
module test_fpmove_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        rec_bit = 1'b0;
  logic        unit_en = 1'b0;
  logic [31:0] stat_word = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [63:0] res_data;
  logic        res_we;
  logic [3:0]  cond_val;
  logic        cond_we;
  logic        unavail_exc;

  int n_vec  = 0;
  int n_fail = 0;
  logic [63:0] mdl_data = '0;
  logic [3:0]  mdl_cond = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fpmove_unit i_fpmove_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .rec_bit(rec_bit), .unit_en(unit_en), .stat_word(stat_word),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data), .res_we(res_we),
    .cond_val(cond_val), .cond_we(cond_we), .unavail_exc(unavail_exc)
  );

  function automatic logic [63:0] pat(input int k);
    case (k)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF0_0000_0000_0000;
      3: return 64'hFFF8_0000_0000_0001;
      4: return 64'h7FF4_0000_0000_BEEF;
      5: return 64'h3FF0_0000_0000_0000;
      6: return 64'hC009_21FB_5444_2D18;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  // Expected result, written in arithmetic form independent of the RTL
  function automatic logic [63:0] expect_res(input int op, input logic [63:0] a,
                                             input logic [63:0] b);
    logic [63:0] top = 64'd1 << 63;
    case (op)
      1: return b & ~top;
      2: return b | top;
      3: return b ^ top;
      4: return (a & top) | (b & ~top);
      5: return ((a >> 32) << 32) | (b >> 32);
      6: return (a << 32) | (b & 64'h0000_0000_FFFF_FFFF);
      default: return b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input int op, input bit en, input bit rec,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] st);
    bit w, c, x;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op[2:0]; unit_en = en; rec_bit = rec;
    opnd_a = a; opnd_b = b; stat_word = st;
    x = !en;
    w = en && (op != 7);
    c = w && rec && (op <= 4);
    if (w) mdl_data = expect_res(op, a, b);
    if (c) mdl_cond = st[31:28];
    @(negedge clk);
    in_valid = 1'b0;
    if (op <= 3)       chk(res_data == mdl_data, "R2 data", res_data, mdl_data);
    else if (op == 4)  chk(res_data == mdl_data, "R3 data", res_data, mdl_data);
    else if (op == 5)  chk(res_data == mdl_data, "R4 data", res_data, mdl_data);
    else if (op == 6)  chk(res_data == mdl_data, "R5 data", res_data, mdl_data);
    else               chk(res_data == mdl_data, "R12 data held", res_data, mdl_data);
    if (!en)           chk(res_data == mdl_data, "R10 data held", res_data, mdl_data);
    if (a[62:52] == 11'h7FF || b[62:52] == 11'h7FF)
      chk(res_data == mdl_data, "R6 nan/inf passthrough", res_data, mdl_data);
    chk(res_we == w, "R7 write strobe", 64'(res_we), 64'(w));
    if (op >= 5 && op <= 6)
      chk(cond_we == 1'b0, "R9 merge cond", 64'(cond_we), 64'd0);
    else
      chk(cond_we == c, "R8 cond strobe", 64'(cond_we), 64'(c));
    chk(cond_val == mdl_cond, "R8 cond value", 64'(cond_val), 64'(mdl_cond));
    chk(unavail_exc == x, "R10 exception", 64'(unavail_exc), 64'(x));
    chk(!(unavail_exc && res_we), "R11 exclusive", 64'({unavail_exc, res_we}), 64'd0);
    // idle cycle: nothing moves
    @(negedge clk);
    chk(!res_we && !cond_we && !unavail_exc, "R7 idle strobes",
        64'({res_we, cond_we, unavail_exc}), 64'd0);
    chk(res_data == mdl_data, "R7 idle hold", res_data, mdl_data);
    chk(cond_val == mdl_cond, "R8 idle hold", 64'(cond_val), 64'(mdl_cond));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res_data == 64'd0 && !res_we && cond_val == 4'd0 && !cond_we && !unavail_exc,
        "R1 reset", res_data, 64'd0);
    rst_n = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int en = 0; en < 2; en++)
        for (int rec = 0; rec < 2; rec++)
          for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
              apply(op, en[0], rec[0], pat(ia), pat((ib + op) % 8) ^ 64'(ib * 4096),
                    {4'(ia ^ ib ^ op), 28'hA5C3_E17});
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule